// File: doc/BRIEF.md
# Synchronizable Four-Event Capture Timer

This block timestamps edges on a single input pin against a free-running counter. Four capture slots are filled one after another. Each slot has its own edge direction, and each can clear the counter once its value is stored. Software can therefore read either absolute timestamps or intervals between successive edges. In one-shot operation the sequencer stops after a chosen slot and waits for a rearm command. In continuous operation it wraps back to the first slot and keeps capturing.

Several copies of the block can share one aligned time base. A sync pulse, arriving from outside or produced by a software strobe, reloads the counter from a phase register. A selectable sync output can pass that pulse on to the next copy, so one software strobe aligns a whole chain in the same cycle. Once the counters are aligned, subtracting the first-slot timestamps of two units gives the phase offset between their inputs.

All registers sit behind a flat write strobe and an address. Reads are combinational from the same address. Register addresses: 0 control, 1 command, 2 phase, 3 counter, 4 flags, 5 to 8 capture slots 1 to 4.

Top module: `cap_timer`

## Requirements
- R1: The counter (address 3) starts at zero after reset and increments by one every clock. When it steps from all ones to zero it sets the wrap flag, bit 4 of the flags register (address 4).
- R2: A captured timestamp equals the counter value read in the cycle in which the input pin changes, plus two (the input passes through a two-stage synchronizer).
- R3: Captures fill slots 1, 2, 3 and 4 in order. Control bit i-1 (address 0) sets the edge direction of slot i: 0 means rising, 1 means falling. An edge of the other direction captures nothing and does not advance the sequence.
- R4: Control bit 3+i enables the counter clear for slot i. When it is set, the counter reads zero in the cycle after that slot's value is stored.
- R5: With control bit 8 at 0 (continuous), the edge after slot 4 is stored in slot 1 again.
- R6: With control bit 8 at 1 (one-shot), capturing stops after slot k+1, where k is control bits 10:9. Writing 1 to command bit 1 (address 1) restarts capturing at slot 1.
- R7: When control bit 11 is set, a one-cycle high on sync_in loads the counter from the phase register (address 2), and the counter does not increment in that cycle. When bit 11 is clear, sync_in has no effect on the counter.
- R8: Writing 1 to command bit 0 raises a one-cycle internal sync. The counter then reads the phase value two clocks after the write, whatever the setting of control bit 11. The command register always reads zero.
- R9: Control bits 13:12 select sync_out: 0 passes sync_in or the software sync through in the same cycle, 1 pulses in the cycle the counter wraps, and any other value holds it low.
- R10: If one unit's sync_out drives another unit's sync_in, a software sync on the first unit leaves both counters equal. The difference of their slot-1 timestamps then equals the delay between their input edges, counted in clocks.
- R11: If a capture and a sync reload fall in the same cycle, the slot stores the count from before the reload.
- R12: Each stored capture sets flag bit i-1 for slot i. The flags stay set until software writes 1 to them, and irq is high while any flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_in | input | 1 | Asynchronous capture input pin |
| sync_in | input | 1 | Synchronous sync pulse from a neighbour or the system |
| sync_out | output | 1 | Selected sync pulse for downstream units |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for both write and read |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Combinational read data |
| irq | output | 1 | High while any sticky flag is set |

## Verification
The assertions check the counter on every cycle. A reload lands on the phase value, a slot clear lands on zero, and every other cycle steps the count by exactly one. They also check that at most one slot stores per cycle, that each store holds the count from the cycle before, and that flags follow stores and wraps. Several behaviours can only be shown by the directed scenarios: the two-clock input latency, edges of the wrong direction being ignored, one-shot stopping and rearm, the gating of sync_in, and sync_out selection. The two-unit chain, where the slot-1 difference must equal the applied input delay, is also covered only by a scenario.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;

  localparam int ADDR_W = 4;
  localparam int N_EVT  = 4;
  localparam int PTR_W  = $clog2(N_EVT);
  localparam int CTRL_W = 2 + 1 + PTR_W + 1 + 2 * N_EVT;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_CMD   = 4'd1;
  localparam logic [ADDR_W-1:0] A_PHASE = 4'd2;
  localparam logic [ADDR_W-1:0] A_COUNT = 4'd3;
  localparam logic [ADDR_W-1:0] A_FLAGS = 4'd4;
  localparam logic [ADDR_W-1:0] A_CAP0  = 4'd5;

  localparam logic [1:0] SO_PASS = 2'd0;
  localparam logic [1:0] SO_WRAP = 2'd1;

  typedef struct packed {
    logic [1:0]       so_sel;
    logic             sync_en;
    logic [PTR_W-1:0] stop_idx;
    logic             oneshot;
    logic [N_EVT-1:0] clr_en;
    logic [N_EVT-1:0] fall_pol;
  } ctrl_t;

endpackage

// File: rtl/cap_timer_inedge.sv
module cap_timer_inedge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);

  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];

endmodule

// File: rtl/cap_timer_tbase.sv
module cap_timer_tbase #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_load,
  input  logic             clr,
  input  logic [CNT_W-1:0] phase,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             step;

  always_comb begin
    step = !sync_load && !clr;
    if (sync_load) begin
      cnt_d = phase;
    end else if (clr) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt  = cnt_q;
  assign wrap = step && (&cnt_q);

endmodule

// File: rtl/cap_timer_seq.sv
module cap_timer_seq
  import cap_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rise,
  input  logic                        fall,
  input  logic [N_EVT-1:0]            fall_pol,
  input  logic [N_EVT-1:0]            clr_en,
  input  logic                        oneshot,
  input  logic [PTR_W-1:0]            stop_idx,
  input  logic                        rearm,
  input  logic [CNT_W-1:0]            cnt,
  output logic [N_EVT-1:0]            cap_hit,
  output logic                        cnt_clr,
  output logic [N_EVT-1:0][CNT_W-1:0] caps
);

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(N_EVT - 1);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;
  logic             halt_q;
  logic             halt_d;
  logic             active;
  logic             edge_sel;
  logic             hit;
  logic             at_stop;

  always_comb begin
    active   = !halt_q || !oneshot;
    edge_sel = fall_pol[ptr_q] ? fall : rise;
    hit      = active && edge_sel;
    at_stop  = oneshot && (ptr_q == stop_idx);
    cnt_clr  = hit && clr_en[ptr_q];
    cap_hit  = '0;
    if (hit) begin
      cap_hit[ptr_q] = 1'b1;
    end

    ptr_d  = ptr_q;
    halt_d = halt_q;
    if (rearm) begin
      ptr_d  = '0;
      halt_d = 1'b0;
    end else if (hit) begin
      if (at_stop || (ptr_q == LAST_PTR)) begin
        ptr_d = '0;
      end else begin
        ptr_d = ptr_q + 1'b1;
      end
      if (at_stop) begin
        halt_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      halt_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      halt_q <= halt_d;
    end
  end

  for (genvar g = 0; g < N_EVT; g++) begin : g_slot
    logic [CNT_W-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (cap_hit[g]) begin
        slot_q <= cnt;
      end
    end
    assign caps[g] = slot_q;
  end

endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_timer_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_in,
  input  logic              sync_in,
  output logic              sync_out,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              irq
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] phase_q, phase_d;
  logic [N_EVT:0]   flags_q, flags_d;
  logic             sw_sync_q, sw_sync_d;

  logic wr_ctrl, wr_cmd, wr_phase, wr_flags;
  logic rearm;
  logic sync_load;
  logic rise, fall;
  logic wrap;
  logic cnt_clr;
  logic [CNT_W-1:0]            cnt;
  logic [N_EVT-1:0]            cap_hit;
  logic [N_EVT-1:0][CNT_W-1:0] caps;

  always_comb begin
    wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
    wr_cmd   = reg_wr && (reg_addr == A_CMD);
    wr_phase = reg_wr && (reg_addr == A_PHASE);
    wr_flags = reg_wr && (reg_addr == A_FLAGS);
    rearm    = wr_cmd && reg_wdata[1];
    sync_load = (sync_in && ctrl_q.sync_en) || sw_sync_q;
  end

  // next state of the register file
  always_comb begin
    ctrl_d    = wr_ctrl ? ctrl_t'(reg_wdata[CTRL_W-1:0]) : ctrl_q;
    phase_d   = wr_phase ? reg_wdata : phase_q;
    sw_sync_d = wr_cmd && reg_wdata[0];
    flags_d   = flags_q;
    if (wr_flags) begin
      flags_d = flags_d & ~reg_wdata[N_EVT:0];
    end
    flags_d = flags_d | {wrap, cap_hit};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q    <= '0;
      phase_q   <= '0;
      flags_q   <= '0;
      sw_sync_q <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_d;
      phase_q   <= phase_d;
      flags_q   <= flags_d;
      sw_sync_q <= sw_sync_d;
    end
  end

  cap_timer_inedge #(
    .STAGES(SYNC_STAGES)
  ) u_inedge (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .din  (cap_in),
    .rise (rise),
    .fall (fall)
  );

  cap_timer_tbase #(
    .CNT_W(CNT_W)
  ) u_tbase (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sync_load(sync_load),
    .clr      (cnt_clr),
    .phase    (phase_q),
    .cnt      (cnt),
    .wrap     (wrap)
  );

  cap_timer_seq #(
    .CNT_W(CNT_W)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rise    (rise),
    .fall    (fall),
    .fall_pol(ctrl_q.fall_pol),
    .clr_en  (ctrl_q.clr_en),
    .oneshot (ctrl_q.oneshot),
    .stop_idx(ctrl_q.stop_idx),
    .rearm   (rearm),
    .cnt     (cnt),
    .cap_hit (cap_hit),
    .cnt_clr (cnt_clr),
    .caps    (caps)
  );

  always_comb begin
    unique case (ctrl_q.so_sel)
      SO_PASS: sync_out = sync_in || sw_sync_q;
      SO_WRAP: sync_out = wrap;
      default: sync_out = 1'b0;
    endcase
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata = CNT_W'(ctrl_q);
      A_PHASE: reg_rdata = phase_q;
      A_COUNT: reg_rdata = cnt;
      A_FLAGS: reg_rdata = CNT_W'(flags_q);
      default: begin
        for (int i = 0; i < N_EVT; i++) begin
          if (reg_addr == A_CAP0 + ADDR_W'(i)) begin
            reg_rdata = caps[i];
          end
        end
      end
    endcase
  end

  assign irq = |flags_q;

endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk
  import cap_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        sync_load,
  input logic                        cnt_clr,
  input logic [CNT_W-1:0]            cnt,
  input logic [CNT_W-1:0]            phase,
  input logic                        wrap,
  input logic [N_EVT-1:0]            cap_hit,
  input logic [N_EVT-1:0][CNT_W-1:0] caps,
  input logic [N_EVT:0]              flags,
  input logic [ADDR_W-1:0]           reg_addr,
  input logic [CNT_W-1:0]            reg_rdata
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  assert_sync_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_load |=> cnt == $past(phase));

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_load && !cnt_clr) |=> cnt == $past(cnt) + ONE);

  assert_slot_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_clr && !sync_load) |=> cnt == '0);

  assert_single_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cap_hit));

  assert_wrap_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flags[N_EVT]);

  assert_cmd_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CMD) |-> reg_rdata == '0);

  for (genvar g = 0; g < N_EVT; g++) begin : g_chk
    assert_prereload_value_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cap_hit[g] |=> caps[g] == $past(cnt));

    assert_flag_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
      cap_hit[g] |=> flags[g]);
  end

endmodule

bind cap_timer cap_timer_chk #(
  .CNT_W(CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .sync_load(sync_load),
  .cnt_clr  (cnt_clr),
  .cnt      (cnt),
  .phase    (phase_q),
  .wrap     (wrap),
  .cap_hit  (cap_hit),
  .caps     (caps),
  .flags    (flags_q),
  .reg_addr (reg_addr),
  .reg_rdata(reg_rdata)
);

// File: tb/cap_timer_tb.sv
module cap_timer_tb;

  localparam int CLK_PERIOD = 10;

  localparam logic [3:0] R_CTRL = 4'd0, R_CMD = 4'd1, R_PHASE = 4'd2,
                         R_COUNT = 4'd3, R_FLAGS = 4'd4, R_CAP1 = 4'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_in = 1'b0, peer_cap = 1'b0, sync_in = 1'b0;
  logic        sync_out, peer_sync_out;
  logic        reg_wr = 1'b0, p_wr = 1'b0;
  logic [3:0]  reg_addr = 4'd0, p_addr = 4'd0;
  logic [31:0] reg_wdata = '0, p_wdata = '0;
  logic [31:0] reg_rdata, p_rdata;
  logic        irq, p_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cap_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .sync_in(sync_in),
    .sync_out(sync_out), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  cap_timer u_peer (
    .clk(clk), .rst_n(rst_n), .cap_in(peer_cap), .sync_in(sync_out),
    .sync_out(peer_sync_out), .reg_wr(p_wr), .reg_addr(p_addr),
    .reg_wdata(p_wdata), .reg_rdata(p_rdata), .irq(p_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pwr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    p_wr = 1'b1; p_addr = a; p_wdata = d;
    @(negedge clk);
    p_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic prd(input logic [3:0] a, output logic [31:0] v);
    p_addr = a;
    #1;
    v = p_rdata;
  endtask

  // toggle cap_in, return count seen in the toggle cycle plus two
  task automatic toggle(output logic [31:0] exp);
    logic [31:0] c;
    @(negedge clk);
    rd(R_COUNT, c);
    cap_in = ~cap_in;
    exp = c + 32'd2;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v, c;
    rd(R_CTRL, v);  check("R1 ctrl reset", v, 32'h0);
    rd(R_FLAGS, v); check("R12 flags reset", v, 32'h0);
    check("R12 irq reset", {31'b0, irq}, 32'h0);
    rd(R_CAP1, v);  check("R2 cap1 reset", v, 32'h0);
    check("R9 sync_out idle", {31'b0, sync_out}, 32'h0);
    @(negedge clk);
    rd(R_COUNT, c);
    @(negedge clk);
    rd(R_COUNT, v); check("R1 count increments", v, c + 32'd1);
  endtask

  task automatic t_swsync();
    logic [31:0] v;
    wr(R_PHASE, 32'd1000);
    wr(R_CMD, 32'h1);
    @(negedge clk);
    rd(R_COUNT, v); check("R8 sw sync loads phase", v, 32'd1000);
    rd(R_CMD, v);   check("R8 cmd reads zero", v, 32'h0);
    @(negedge clk);
    rd(R_COUNT, v); check("R1 count after reload", v, 32'd1001);
  endtask

  task automatic t_seq_cont();
    logic [31:0] e [4];
    logic [31:0] v, e5;
    wr(R_CTRL, 32'h0000_000A);
    for (int k = 0; k < 4; k++) toggle(e[k]);
    for (int k = 0; k < 4; k++) begin
      rd(R_CAP1 + 4'(k), v);
      check("R3 ordered slot with its polarity", v, e[k]);
    end
    rd(R_FLAGS, v); check("R12 all slot flags", v, 32'hF);
    check("R12 irq set", {31'b0, irq}, 32'h1);
    wr(R_FLAGS, 32'h5);
    rd(R_FLAGS, v); check("R12 write one clears", v, 32'hA);
    toggle(e5);
    rd(R_CAP1, v); check("R5 continuous wraps to slot 1", v, e5);
    wr(R_FLAGS, 32'h1F);
    check("R12 irq cleared", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_oneshot();
    logic [31:0] v, e, c1, c3;
    wr(R_CTRL, 32'h0000_0300);
    wr(R_CMD, 32'h2);
    rd(R_CAP1, c1);
    toggle(e);
    rd(R_CAP1, v);  check("R3 wrong edge ignored", v, c1);
    rd(R_FLAGS, v); check("R3 wrong edge sets no flag", v, 32'h0);
    toggle(e);
    rd(R_CAP1, v);  check("R2 one-shot slot 1", v, e);
    toggle(e);
    toggle(e);
    rd(R_CAP1 + 4'd1, v); check("R6 one-shot slot 2", v, e);
    rd(R_CAP1 + 4'd2, c3);
    rd(R_CAP1, c1);
    toggle(e);
    toggle(e);
    rd(R_CAP1 + 4'd2, v); check("R6 halted slot 3 unchanged", v, c3);
    rd(R_CAP1, v);        check("R6 halted slot 1 unchanged", v, c1);
    rd(R_FLAGS, v);       check("R6 only two flags", v, 32'h3);
    wr(R_CMD, 32'h2);
    wr(R_FLAGS, 32'h1F);
    toggle(e);
    toggle(e);
    rd(R_CAP1, v); check("R6 rearm restarts slot 1", v, e);
  endtask

  task automatic t_delta();
    logic [31:0] v, c, e;
    wr(R_CTRL, 32'h0000_0010);
    wr(R_CMD, 32'h2);
    toggle(e);
    @(negedge clk);
    rd(R_COUNT, c);
    cap_in = 1'b1;
    repeat (3) @(negedge clk);
    rd(R_COUNT, v); check("R4 counter cleared after slot 1", v, 32'h0);
    rd(R_CAP1, v);  check("R4 slot 1 value", v, c + 32'd2);
    toggle(e);
    @(negedge clk);
    rd(R_COUNT, c);
    cap_in = 1'b1;
    repeat (3) @(negedge clk);
    rd(R_COUNT, v); check("R4 no clear for slot 2", v, c + 32'd3);
    rd(R_CAP1 + 4'd1, v); check("R4 slot 2 value", v, c + 32'd2);
  endtask

  task automatic t_syncin();
    logic [31:0] v, c;
    wr(R_CTRL, 32'h0);
    wr(R_PHASE, 32'd500);
    @(negedge clk);
    rd(R_COUNT, c);
    sync_in = 1'b1;
    #1;
    check("R9 pass-through sync_out", {31'b0, sync_out}, 32'h1);
    @(negedge clk);
    sync_in = 1'b0;
    rd(R_COUNT, v); check("R7 sync_in ignored when disabled", v, c + 32'd1);
    wr(R_CTRL, 32'h0000_0800);
    @(negedge clk);
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    rd(R_COUNT, v); check("R7 sync_in loads phase", v, 32'd500);
  endtask

  task automatic t_sync_cap();
    logic [31:0] v, c, e;
    wr(R_CMD, 32'h2);
    toggle(e);
    @(negedge clk);
    rd(R_COUNT, c);
    cap_in = 1'b1;
    repeat (2) @(negedge clk);
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    rd(R_CAP1, v);  check("R11 capture keeps pre-reload count", v, c + 32'd2);
    rd(R_COUNT, v); check("R11 reload still applied", v, 32'd500);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    wr(R_FLAGS, 32'h1F);
    wr(R_CTRL, 32'h0000_1000);
    wr(R_PHASE, 32'hFFFF_FFFD);
    wr(R_CMD, 32'h1);
    repeat (3) @(negedge clk);
    rd(R_COUNT, v); check("R1 count at all ones", v, 32'hFFFF_FFFF);
    check("R9 wrap pulse on sync_out", {31'b0, sync_out}, 32'h1);
    rd(R_FLAGS, v); check("R1 no wrap flag yet", v, 32'h0);
    @(negedge clk);
    rd(R_COUNT, v); check("R1 count wrapped", v, 32'h0);
    rd(R_FLAGS, v); check("R1 wrap flag", v, 32'h10);
    check("R9 wrap pulse ends", {31'b0, sync_out}, 32'h0);
  endtask

  task automatic t_chain();
    logic [31:0] v, pv, e, dcap, pcap;
    wr(R_CTRL, 32'h0);
    wr(R_PHASE, 32'h0);
    wr(R_CMD, 32'h2);
    pwr(R_CTRL, 32'h0000_0800);
    toggle(e);
    wr(R_CMD, 32'h1);
    @(negedge clk);
    rd(R_COUNT, v);
    prd(R_COUNT, pv);
    check("R10 dut aligned", v, 32'h0);
    check("R10 peer aligned", pv, 32'h0);
    @(negedge clk);
    cap_in = 1'b1;
    repeat (7) @(negedge clk);
    peer_cap = 1'b1;
    repeat (4) @(negedge clk);
    rd(R_CAP1, dcap);
    prd(R_CAP1, pcap);
    check("R10 slot-1 difference equals delay", pcap - dcap, 32'd7);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_swsync();
    t_seq_cont();
    t_oneshot();
    t_delta();
    t_syncin();
    t_sync_cap();
    t_overflow();
    t_chain();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule